// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block watches the CPU bus and raises a break request toward the debug controller when the current address equals one of four programmed breakpoint addresses. Each breakpoint is a 24-bit value that the debug side loads one byte at a time through a write-only register port. A control register holds one enable bit per breakpoint. A breakpoint whose enable bit is clear never takes part in matching.

The compared address depends on the CPU mode. In 24-bit linear mode the whole address bus is compared. In 16-bit compatibility mode the compared address is an 8-bit memory base value placed above the low 16 bits of the bus.

A match on the first opcode fetch of an instruction requests a break at once. A match on any other bus cycle is held as pending, and the break is requested when the current instruction ends. The request stays high until the debug controller acknowledges it. While a break is pending or requested, further matches are ignored. When several breakpoints match in the same cycle they form a single break, and the lowest matching index is reported.

Top module: `hw_brkpt_unit`

## Requirements
- R1: Register map of the write port: breakpoint k, byte b sits at address 3k+b. Byte b=0 holds bits 7:0, b=1 holds bits 15:8 and b=2 holds bits 23:16. A write changes only the addressed byte. Address 12 is the enable register, and data bits 3:0 enable breakpoints 0 to 3.
- R2: A breakpoint whose enable bit is 0 never matches. Reset clears all enable bits.
- R3: With linearMode=1 the compared address is busAddr[23:0], and memBase has no effect.
- R4: With linearMode=0 the compared address is {memBase, busAddr[15:0]}, and busAddr[23:16] has no effect.
- R5: No match is taken in a cycle where addrValid is 0.
- R6: A match taken with firstFetch=1 drives breakReq high from the clock edge that samples the match.
- R7: A match taken with firstFetch=0 and instrEnd=0 is held as pending and does not raise breakReq. breakReq rises at the edge that samples instrEnd=1. A match taken with firstFetch=0 and instrEnd=1 breaks at once.
- R8: breakReq stays high until debugAck=1 is sampled, and it is low from that edge on.
- R9: While a break is pending or breakReq is high, a match starts no new break and leaves matchIdx unchanged.
- R10: Several matches in one cycle give one break, and matchIdx records the lowest matching index. matchIdx resets to 0.
- R11: Reset drives breakReq low and discards any pending break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addrValid | input | 1 | The bus carries a valid address this cycle |
| busAddr | input | 24 | CPU address bus |
| memBase | input | 8 | Memory base value used in compatibility mode |
| linearMode | input | 1 | 1 = 24-bit linear mode, 0 = 16-bit compatibility mode |
| firstFetch | input | 1 | The cycle is the first opcode fetch of an instruction |
| instrEnd | input | 1 | The instruction in progress ends this cycle |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register write address |
| regWrData | input | 8 | Register write data |
| debugAck | input | 1 | Debug controller acknowledges the break |
| breakReq | output | 1 | Break request, held until acknowledged |
| matchIdx | output | 2 | Lowest breakpoint index that caused the last break |

## Verification
Every result of this block is registered, so each one is due exactly one clock edge after the input that causes it.
- An immediate break shows on breakReq one edge after the matching bus cycle.
- A deferred break shows one edge after the cycle that carries instrEnd.
- breakReq drops one edge after debugAck.
- matchIdx takes its new value on the same edge as the break it belongs to.

The bench changes inputs on the falling edge and samples on the next falling edge, which places each check in the cycle where its result is due. Each check that a match was ignored then drives instrEnd or debugAck and confirms that no break appears and no pending break is left behind.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic cmpHold;     // a break is pending or requested: ignore matches
    logic captureIdx;  // a new break starts this cycle: record the index
  } ctlStrobe_t;
endpackage

// File: rtl/brkpt_datapath.sv
module brkpt_datapath
  import brkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 24,
  parameter int BASE_W = 8,
  parameter int REG_AW = 4,
  localparam int BYTES = ADDR_W / 8,
  localparam int OFS_W = ADDR_W - BASE_W,
  localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int CTRL_ADDR = NUM_BP * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BASE_W-1:0] memBase,
  input  logic              linearMode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [7:0]        regWrData,
  input  ctlStrobe_t        strobe,
  output logic              anyHit,
  output logic [IDX_W-1:0]  matchIdx
);
  logic [NUM_BP-1:0] enableReg;
  logic [NUM_BP-1:0] hitVec;
  logic [ADDR_W-1:0] cmpAddr;
  logic [IDX_W-1:0]  lowIdx;

  // The compared address depends on the mode
  assign cmpAddr = linearMode ? busAddr : {memBase, busAddr[OFS_W-1:0]};

  // Enable register: cleared at reset so the unreset address bytes are harmless
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enableReg <= '0;
    else if (regWrEn && regWrAddr == REG_AW'(CTRL_ADDR))
      enableReg <= regWrData[NUM_BP-1:0];
  end

  for (genvar k = 0; k < NUM_BP; k++) begin : gSet
    logic [ADDR_W-1:0] setAddr;
    // Byte-wise write-only storage, no reset
    always_ff @(posedge clk) begin
      for (int b = 0; b < BYTES; b++) begin
        if (regWrEn && regWrAddr == REG_AW'(k * BYTES + b))
          setAddr[8*b +: 8] <= regWrData;
      end
    end
    assign hitVec[k] = addrValid && enableReg[k] && !strobe.cmpHold &&
                       (setAddr == cmpAddr);
  end

  assign anyHit = |hitVec;

  // The lowest matching index wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (hitVec[i]) lowIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) matchIdx <= '0;
    else if (strobe.captureIdx) matchIdx <= lowIdx;
  end

  AST_IDX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.captureIdx |=> $stable(matchIdx)); // R9
  AST_NO_HIT_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !addrValid |-> !anyHit); // R5
endmodule

// File: rtl/brkpt_control.sv
module brkpt_control
  import brkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyHit,
  input  logic       firstFetch,
  input  logic       instrEnd,
  input  logic       debugAck,
  output ctlStrobe_t strobe,
  output logic       breakReq
);
  logic pending;
  logic busy;

  assign busy = breakReq || pending;
  assign strobe.cmpHold = busy;
  assign strobe.captureIdx = anyHit && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      breakReq <= 1'b0;
      pending  <= 1'b0;
    end else if (breakReq) begin
      if (debugAck) breakReq <= 1'b0;
    end else if (pending) begin
      if (instrEnd) begin
        breakReq <= 1'b1;
        pending  <= 1'b0;
      end
    end else if (anyHit) begin
      if (firstFetch || instrEnd) breakReq <= 1'b1;
      else pending <= 1'b1;
    end
  end

  AST_IMMEDIATE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && anyHit && firstFetch) |=> breakReq); // R6
  AST_DEFERRED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && anyHit && !firstFetch && !instrEnd) |=> !breakReq); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (breakReq && !debugAck) |=> breakReq); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (breakReq && debugAck) |=> !breakReq); // R8
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && breakReq)); // R9
endmodule

// File: rtl/hw_brkpt_unit.sv
module hw_brkpt_unit
  import brkpt_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 24,
  parameter int BASE_W = 8,
  parameter int REG_AW = 4,
  localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BASE_W-1:0] memBase,
  input  logic              linearMode,
  input  logic              firstFetch,
  input  logic              instrEnd,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [7:0]        regWrData,
  input  logic              debugAck,
  output logic              breakReq,
  output logic [IDX_W-1:0]  matchIdx
);
  ctlStrobe_t strobe;
  logic       anyHit;

  brkpt_datapath #(
    .NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .REG_AW(REG_AW)
  ) uDatapath (
    .clk(clk), .rst_n(rst_n), .addrValid(addrValid), .busAddr(busAddr),
    .memBase(memBase), .linearMode(linearMode), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .strobe(strobe),
    .anyHit(anyHit), .matchIdx(matchIdx)
  );

  brkpt_control uControl (
    .clk(clk), .rst_n(rst_n), .anyHit(anyHit), .firstFetch(firstFetch),
    .instrEnd(instrEnd), .debugAck(debugAck), .strobe(strobe),
    .breakReq(breakReq)
  );
endmodule

// File: tb/hw_brkpt_unit_test.sv
module hw_brkpt_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addrValid = 1'b0;
  logic [23:0] busAddr = '0;
  logic [7:0]  memBase = '0;
  logic        linearMode = 1'b1;
  logic        firstFetch = 1'b0;
  logic        instrEnd = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrAddr = '0;
  logic [7:0]  regWrData = '0;
  logic        debugAck = 1'b0;
  logic        breakReq;
  logic [1:0]  matchIdx;

  int total = 0;
  int bad = 0;

  hw_brkpt_unit uut (
    .clk(clk), .rst_n(rst_n), .addrValid(addrValid), .busAddr(busAddr),
    .memBase(memBase), .linearMode(linearMode), .firstFetch(firstFetch),
    .instrEnd(instrEnd), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .debugAck(debugAck), .breakReq(breakReq),
    .matchIdx(matchIdx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Vector: lin ff ie vld addr[24] base[8] expImm expPend expIdx[2]
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,1'b1,24'h123456,8'h00,1'b1,1'b0,2'd0}, // R3 R6
    {1'b1,1'b1,1'b0,1'b1,24'hABCDEF,8'h00,1'b1,1'b0,2'd1}, // R10 lowest of 1,2
    {1'b1,1'b0,1'b0,1'b1,24'h123456,8'h00,1'b0,1'b1,2'd0}, // R7 deferred
    {1'b1,1'b0,1'b1,1'b1,24'h550100,8'h00,1'b1,1'b0,2'd3}, // R7 ends same cycle
    {1'b0,1'b1,1'b0,1'b1,24'hFF3456,8'h12,1'b1,1'b0,2'd0}, // R4 base replaces upper
    {1'b0,1'b1,1'b0,1'b1,24'h123456,8'h00,1'b0,1'b0,2'd0}, // R4 upper bus ignored
    {1'b1,1'b1,1'b0,1'b1,24'h123457,8'h00,1'b0,1'b0,2'd0}, // R3 one bit off
    {1'b1,1'b1,1'b0,1'b0,24'h123456,8'h00,1'b0,1'b0,2'd0}, // R5 not valid
    {1'b0,1'b0,1'b0,1'b1,24'h000100,8'h55,1'b0,1'b1,2'd3}, // R4 R7 deferred
    {1'b1,1'b1,1'b0,1'b1,24'h003456,8'h12,1'b0,1'b0,2'd0}  // R3 base ignored
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic loadSet(input int k, input logic [23:0] v);
    for (int b = 0; b < 3; b++) wrReg(4'(3 * k + b), v[8*b +: 8]);
  endtask

  // One bus cycle, then sample after the edge
  task automatic busCycle(input logic lin, input logic ff, input logic ie,
                          input logic vld, input logic [23:0] a,
                          input logic [7:0] base);
    linearMode = lin; firstFetch = ff; instrEnd = ie; addrValid = vld;
    busAddr = a; memBase = base;
    @(negedge clk);
    addrValid = 1'b0; firstFetch = 1'b0; instrEnd = 1'b0;
  endtask

  task automatic endInstr();
    instrEnd = 1'b1;
    @(negedge clk);
    instrEnd = 1'b0;
  endtask

  task automatic ack();
    debugAck = 1'b1;
    @(negedge clk);
    debugAck = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset breakReq", int'(breakReq), 0);
    check("R10 reset matchIdx", int'(matchIdx), 0);
    rst_n = 1'b1;
    @(negedge clk);

    loadSet(0, 24'h123456);
    loadSet(1, 24'hABCDEF);
    loadSet(2, 24'hABCDEF);
    loadSet(3, 24'h550100);
    wrReg(4'd12, 8'h0F);

    // R2 R11: reset clears enables and pending
    busCycle(1, 0, 0, 1, 24'h123456, 8'h00);
    check("R7 pending before reset", int'(breakReq), 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    endInstr();
    check("R11 pending discarded", int'(breakReq), 0);
    busCycle(1, 1, 0, 1, 24'h123456, 8'h00);
    check("R2 enables cleared by reset", int'(breakReq), 0);
    wrReg(4'd12, 8'h0F);

    // Table-driven main function
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      busCycle(v[39], v[38], v[37], v[36], v[35:12], v[11:4]);
      check($sformatf("R6 R7 vec%0d immediate", i), int'(breakReq), int'(v[3]));
      endInstr();
      check($sformatf("R7 vec%0d after end", i), int'(breakReq), int'(v[3] | v[2]));
      if (breakReq) begin
        check($sformatf("R10 vec%0d index", i), int'(matchIdx), int'(v[1:0]));
        ack();
        check($sformatf("R8 vec%0d ack drops", i), int'(breakReq), 0);
      end
    end

    // R8: held without ack
    busCycle(1, 1, 0, 1, 24'hABCDEF, 8'h00);
    repeat (4) @(negedge clk);
    check("R8 held without ack", int'(breakReq), 1);

    // R9: match while requested is ignored
    busCycle(1, 1, 0, 1, 24'h123456, 8'h00);
    check("R9 index kept while requested", int'(matchIdx), 1);
    ack();
    check("R8 drop after ack", int'(breakReq), 0);
    endInstr();
    check("R9 nothing left pending", int'(breakReq), 0);

    // R9: match while pending is ignored
    busCycle(1, 0, 0, 1, 24'h550100, 8'h00);
    check("R7 pending no request", int'(breakReq), 0);
    busCycle(1, 1, 0, 1, 24'h123456, 8'h00);
    check("R9 fetch match while pending ignored", int'(breakReq), 0);
    endInstr();
    check("R7 deferred break raised", int'(breakReq), 1);
    check("R9 index kept while pending", int'(matchIdx), 3);
    ack();

    // R2: disable set 1, set 2 takes over
    wrReg(4'd12, 8'h0D);
    busCycle(1, 1, 0, 1, 24'hABCDEF, 8'h00);
    check("R2 disabled set skipped", int'(breakReq), 1);
    check("R2 R10 next set index", int'(matchIdx), 2);
    ack();
    wrReg(4'd12, 8'h09);
    busCycle(1, 1, 0, 1, 24'hABCDEF, 8'h00);
    check("R2 both disabled no break", int'(breakReq), 0);

    // R1: rewrite the upper byte of set 0 only
    wrReg(4'd2, 8'h77);
    busCycle(1, 1, 0, 1, 24'h123456, 8'h00);
    check("R1 old address gone", int'(breakReq), 0);
    busCycle(1, 1, 0, 1, 24'h773456, 8'h00);
    check("R1 byte write matches", int'(breakReq), 1);
    check("R1 index", int'(matchIdx), 0);
    ack();
    check("R8 final drop", int'(breakReq), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule